// File: doc/BRIEF.md
# Flash Erase-Block Protection Gate

This block keeps a protection record for every erase block of a banked flash array. Each record holds a lock bit and a lock-down flag. Commands arrive one per clock and name a block index. The command sets the lock, clears it, or locks the block and pins it down. A write-protect level decides whether a pinned-down block may still change state. A reset returns every record to locked.

A program or erase request names a block. The block returns one grant or deny pulse per request, and it refuses every request when the program-voltage indication is below the lockout level. A granted request raises a busy flag. Busy stays set until the operation reports completion, and changes to the voltage indication or to the protection records do not clear it. A combinational read port shows the lock and lock-down bits of any block.

Top module: `flk_lock_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, every block reads locked=1 and down=0, and `grant`, `deny` and `busy` are 0.
- R2: One command is taken per clock when `cmd_valid` is high. The `cmd_op` encodings are 2'b01 lock (locked=1), 2'b10 unlock (locked=0) and 2'b11 lock-down (locked=1, down=1). The new state shows on the read port after that clock edge. A request in a later cycle is judged against the new state. A request in the same cycle is judged against the state before the command.
- R3: While `wp_level` is 0, no command changes a block whose down flag is 1.
- R4: While `wp_level` is 1, a block whose down flag is 1 takes lock and unlock like any other block. Unlock clears only the lock bit. The down flag is cleared only by reset.
- R5: A request (`req_valid` high) produces exactly one pulse one clock later. The pulse is `grant` when the named block's lock bit is 0, `vpp_ok` is 1 and `busy` is 0. Otherwise the pulse is `deny`.
- R6: With `vpp_ok` low, every request is denied, whatever the block states.
- R7: `busy` is set by a grant and is cleared only by `op_done` or reset. It does not react to `vpp_ok`. Commands taken while `busy` is set still update the records.
- R8: `rd_locked` and `rd_down` show the state of block `rd_blk` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns all blocks to locked |
| cmd_valid | input | 1 | A protection command is present this cycle |
| cmd_op | input | 2 | Command code: 01 lock, 10 unlock, 11 lock-down |
| cmd_blk | input | IDX_W | Block named by the command |
| wp_level | input | 1 | Write-protect level; 0 freezes pinned-down blocks |
| vpp_ok | input | 1 | Program voltage at or above the lockout level |
| req_valid | input | 1 | A program/erase start request |
| req_blk | input | IDX_W | Block named by the request |
| op_done | input | 1 | The running operation has finished |
| grant | output | 1 | One-cycle pulse: request accepted |
| deny | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | An accepted operation is running |
| rd_blk | input | IDX_W | Block selected for status read |
| rd_locked | output | 1 | Lock bit of the selected block |
| rd_down | output | 1 | Lock-down flag of the selected block |

## Verification
The assertions assume that block indices stay below the block count. They also assume that `op_done` may arrive at any time, even when nothing is running. The checks on frozen or sticky state count only cycles in which `rd_blk` did not change, so a moving read index does not look like a state change. The bench keeps every index in range and holds `rd_blk` steady for most cycles. It drives all other inputs freely, including commands and requests to the same block in the same cycle.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    FLK_NOP    = 2'b00,
    FLK_LOCK   = 2'b01,
    FLK_UNLOCK = 2'b10,
    FLK_DOWN   = 2'b11
  } flk_op_e;

  typedef struct packed {
    logic locked;
    logic down;
  } flk_state_t;

  localparam flk_state_t FLK_RESET_ST = '{locked: 1'b1, down: 1'b0};
endpackage

// File: rtl/flk_cell.sv
module flk_cell
  import flk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [1:0] op,
  input  logic       wp_level,
  output flk_state_t st
);
  flk_state_t st_q, st_d;
  logic       frozen;
  logic       en;

  // A pinned-down block is frozen while write-protect is low (R3)
  assign frozen = st_q.down & ~wp_level;
  assign en     = sel & ~frozen & (op != FLK_NOP);

  always_comb begin
    st_d = st_q;
    case (flk_op_e'(op))
      FLK_LOCK:   st_d.locked = 1'b1;
      FLK_UNLOCK: st_d.locked = 1'b0;   // down flag kept (R4)
      FLK_DOWN: begin
        st_d.locked = 1'b1;
        st_d.down   = 1'b1;
      end
      default:    st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= FLK_RESET_ST;
    else if (en) st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/flk_start_ctrl.sv
module flk_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic blk_locked,
  input  logic vpp_ok,
  input  logic op_done,
  output logic grant,
  output logic deny,
  output logic busy
);
  logic ok;
  logic grant_d, deny_d, busy_d;

  // Voltage is looked at only here, at the start of an operation
  assign ok = ~blk_locked & vpp_ok & ~busy;

  always_comb begin
    grant_d = req_valid & ok;
    deny_d  = req_valid & ~ok;
    if (grant_d)      busy_d = 1'b1;
    else if (op_done) busy_d = 1'b0;
    else              busy_d = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
      busy  <= 1'b0;
    end else begin
      grant <= grant_d;
      deny  <= deny_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/flk_lock_unit.sv
module flk_lock_unit
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             wp_level,
  input  logic             vpp_ok,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_blk,
  input  logic             op_done,
  output logic             grant,
  output logic             deny,
  output logic             busy,
  input  logic [IDX_W-1:0] rd_blk,
  output logic             rd_locked,
  output logic             rd_down
);
  flk_state_t blk_st [NUM_BLOCKS];
  logic       req_locked;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    flk_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (cmd_valid && (cmd_blk == IDX_W'(g))),
      .op       (cmd_op),
      .wp_level (wp_level),
      .st       (blk_st[g])
    );
  end

  // Out-of-range indices read as locked
  always_comb begin
    req_locked = 1'b1;
    rd_locked  = 1'b1;
    rd_down    = 1'b0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (req_blk == IDX_W'(i)) req_locked = blk_st[i].locked;
      if (rd_blk == IDX_W'(i)) begin
        rd_locked = blk_st[i].locked;
        rd_down   = blk_st[i].down;
      end
    end
  end

  flk_start_ctrl u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .blk_locked (req_locked),
    .vpp_ok     (vpp_ok),
    .op_done    (op_done),
    .grant      (grant),
    .deny       (deny),
    .busy       (busy)
  );
endmodule

// File: rtl/flk_lock_unit_chk.sv
module flk_lock_unit_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_blk,
  input logic             wp_level,
  input logic             vpp_ok,
  input logic             req_valid,
  input logic             op_done,
  input logic             grant,
  input logic             deny,
  input logic             busy,
  input logic [IDX_W-1:0] rd_blk,
  input logic             rd_locked,
  input logic             rd_down
);
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  a_r5_pulse_per_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || deny));

  a_r6_vpp_low_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vpp_ok) |=> (deny && !grant));

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

  a_r7_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !grant);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_down && !wp_level && cmd_valid && cmd_blk == rd_blk)
      |=> (rd_blk != $past(rd_blk)) || (rd_locked == $past(rd_locked)));

  a_r4_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_down |=> (rd_blk != $past(rd_blk)) || rd_down);
endmodule

bind flk_lock_unit flk_lock_unit_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_blk(cmd_blk), .wp_level(wp_level), .vpp_ok(vpp_ok),
  .req_valid(req_valid), .op_done(op_done), .grant(grant), .deny(deny),
  .busy(busy), .rd_blk(rd_blk), .rd_locked(rd_locked), .rd_down(rd_down)
);

// File: tb/test_flk_lock_unit.sv
module test_flk_lock_unit;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [W-1:0] cmd_blk;
  logic wp_level, vpp_ok, req_valid, op_done;
  logic [W-1:0] req_blk, rd_blk;
  logic grant, deny, busy, rd_locked, rd_down;

  always #10 clk = ~clk;

  flk_lock_unit #(.NUM_BLOCKS(N)) i_flk_lock_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .wp_level(wp_level), .vpp_ok(vpp_ok),
    .req_valid(req_valid), .req_blk(req_blk), .op_done(op_done),
    .grant(grant), .deny(deny), .busy(busy), .rd_blk(rd_blk),
    .rd_locked(rd_locked), .rd_down(rd_down)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";
  int mlk[N];
  int mdn[N];
  int mbusy, mgrant, mdeny;

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic idle();
    cmd_valid = 0; cmd_op = 2'b00; req_valid = 0; op_done = 0;
  endtask

  // One clock: model follows the posedge, outputs compared at the negedge
  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mlk[i] = 1; mdn[i] = 0; end
      mbusy = 0; mgrant = 0; mdeny = 0;
    end else begin
      int ok;
      ok = (mlk[req_blk] == 0) && vpp_ok && !mbusy;
      mgrant = req_valid && ok;
      mdeny  = req_valid && !ok;
      if (mgrant) mbusy = 1;
      else if (op_done) mbusy = 0;
      if (cmd_valid && !(mdn[cmd_blk] == 1 && !wp_level)) begin
        if (cmd_op == 2'b01) mlk[cmd_blk] = 1;
        else if (cmd_op == 2'b10) mlk[cmd_blk] = 0;
        else if (cmd_op == 2'b11) begin mlk[cmd_blk] = 1; mdn[cmd_blk] = 1; end
      end
    end
    @(negedge clk);
    chk(tag, "grant", grant, mgrant);
    chk(tag, "deny", deny, mdeny);
    chk(tag, "busy", busy, mbusy);
    chk(tag, "rd_locked", rd_locked, mlk[rd_blk]);
    chk(tag, "rd_down", rd_down, mdn[rd_blk]);
  endtask

  task automatic cmd(input logic [1:0] op, input int b);
    cmd_valid = 1; cmd_op = op; cmd_blk = W'(b); rd_blk = W'(b);
    tick();
    idle();
  endtask

  task automatic req(input int b);
    req_valid = 1; req_blk = W'(b);
    tick();
    idle();
  endtask

  task automatic sweep();
    // R8: read port follows rd_blk within the cycle
    for (int i = 0; i < N; i++) begin
      rd_blk = W'(i);
      #1;
      chk(tag, "sweep locked", rd_locked, mlk[i]);
      chk(tag, "sweep down", rd_down, mdn[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); cmd_blk = 0; req_blk = 0; rd_blk = 0;
    wp_level = 0; vpp_ok = 1;
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tag = "R1";
    tick();
    tag = "R8"; sweep();
    tag = "R1"; req(3);                        // locked after reset -> deny

    tag = "R2"; cmd(2'b10, 3);                 // unlock 3
    req(3);                                     // grant
    tag = "R7"; req(3);                        // busy -> deny
    vpp_ok = 0; tick(); tick();                 // busy ignores voltage
    vpp_ok = 1;
    cmd(2'b01, 3);                              // lock while busy updates status
    op_done = 1; tick(); idle();

    tag = "R6"; cmd(2'b10, 7); vpp_ok = 0; req(7); vpp_ok = 1;
    tag = "R5"; req(7); op_done = 1; tick(); idle();

    tag = "R2";                                 // same cycle: old state used
    cmd_valid = 1; cmd_op = 2'b01; cmd_blk = 7; req_valid = 1; req_blk = 7;
    rd_blk = 7; tick(); idle();
    op_done = 1; tick(); idle();
    req(7);                                     // now locked -> deny

    tag = "R3"; wp_level = 0;
    cmd(2'b11, 5); cmd(2'b10, 5); cmd(2'b01, 5);
    tag = "R4"; wp_level = 1;
    cmd(2'b10, 5); req(5); op_done = 1; tick(); idle();
    tag = "R3"; wp_level = 0; cmd(2'b01, 5);   // frozen while unlocked
    tag = "R4"; wp_level = 1; cmd(2'b01, 5);
    tag = "R8"; sweep();

    tag = "R1"; rd_blk = 5;
    @(negedge clk); rst_n = 0; #1;
    chk("R1", "async locked", rd_locked, 1);
    chk("R1", "async down", rd_down, 0);
    tick(); rst_n = 1; tick();
    sweep();

    tag = "R2";
    for (int k = 0; k < 2000; k++) begin
      cmd_valid = ($urandom % 2) != 0;
      cmd_op    = 2'($urandom);
      cmd_blk   = W'($urandom);
      wp_level  = ($urandom % 3) != 0;
      vpp_ok    = ($urandom % 5) != 0;
      req_valid = ($urandom % 3) == 0;
      req_blk   = W'($urandom);
      op_done   = ($urandom % 4) == 0;
      if (($urandom % 4) == 0) rd_blk = W'($urandom);
      tick();
    end
    idle();
    tag = "R8"; sweep();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule